// File: doc/BRIEF.md
# EPROM Program-and-Verify Sequencer

This block burns one byte into a one-time-programmable parallel memory and then reads it back. The host presents a 13-bit address and an 8-bit value with a one-cycle start pulse. The sequencer then drives the memory's control pins in a fixed order:

- raise the core supply;
- enable the programming supply;
- drive address and data;
- pull chip enable low;
- apply one program pulse;
- hold the data;
- release the bus and open the output for the read-back;
- step everything back down.

When it finishes, it reports whether the byte read back equals the byte written. Supply switching is represented only by two digital enables.

Every interval is a whole number of clock cycles. Each interval is the rounded-up quotient of a time parameter in nanoseconds and the clock period, which is given as a frequency parameter in kHz. Default timings:

| Interval | Time |
|---|---|
| Setup and hold steps | 2 µs each |
| Program pulse | 100 µs |
| Read access allowance | 100 ns |
| Bus float allowance | 130 ns |

At 125 MHz these give 250, 12500, 13 and 17 cycles.

Top module: `eprom_prog_seq`

## Requirements
- R1: After reset the block is at rest. Both supply enables are 0, `ceN`, `oeN` and `pgmN` are 1, `memDataOeO` is 0, and `busyO`, `doneO` and `passO` are 0.
- R2: The programming supply follows the raised core supply. `vppEnO` rises exactly SETUP cycles after `vccHiEnO` rises. `vccHiEnO` falls exactly SETUP cycles after `vppEnO` falls. `vppEnO` is never 1 while `vccHiEnO` is 0.
- R3: Address and data are driven, with `memDataOeO`=1, exactly 2*SETUP cycles before `pgmN` falls. `ceN` falls exactly SETUP cycles before `pgmN` falls.
- R4: `pgmN` stays low for exactly PULSE cycles. This is 12500 at the defaults, inside the 95–105 µs window.
- R5: While `pgmN` is low, `ceN` is 0, `oeN` is 1, `vppEnO` is 1 and the bus is driven.
- R6: After `pgmN` rises, the controller keeps driving the data for exactly HOLD cycles. `oeN` then falls in the same cycle as `memDataOeO` falls. The bus is never driven while `oeN` is 0.
- R7: `oeN` stays low for exactly ACCESS cycles. The read-back is sampled at the end of that window. `passO` is 1 only when the sampled byte equals the written byte; a byte that cannot be programmed because earlier programming cleared its bits yields 0.
- R8: `ceN` rises and `vppEnO` falls exactly FLOAT cycles after `oeN` rises.
- R9: `doneO` is a one-cycle pulse, raised one cycle after `vccHiEnO` falls, with both supplies already off. `passO` holds its value after `doneO` until the next accepted start.
- R10: A start pulse while `busyO` is 1 is ignored: exactly one `doneO` appears per accepted start.
- R11: Address and data are captured at the accepted start. Later changes on `addrI`/`dataI` do not alter `memAddrO`/`memDataO` during the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startI | input | 1 | One-cycle request to program and verify |
| addrI | input | 13 | Target address |
| dataI | input | 8 | Byte to write |
| busyO | output | 1 | Operation in progress |
| doneO | output | 1 | One-cycle completion pulse |
| passO | output | 1 | Read-back matched the written byte |
| memAddrO | output | 13 | Address to the memory |
| memDataO | output | 8 | Data driven to the memory |
| memDataOeO | output | 1 | 1 = controller drives the data bus |
| memDataI | input | 8 | Data returned by the memory |
| vccHiEnO | output | 1 | Raised core-supply enable |
| vppEnO | output | 1 | Programming-supply enable |
| ceN | output | 1 | Chip enable, active low |
| oeN | output | 1 | Output enable, active low |
| pgmN | output | 1 | Program strobe, active low |

## Verification
The start pulse is sampled at edge E. After that, the pin events fall due at fixed offsets from E:

| Event | Cycles after E |
|---|---|
| Programming supply and bus drive on | 250 |
| `ceN` falls | 500 |
| Program pulse starts | 750 |
| Program pulse ends | 13250 |
| `oeN` falls | 13500 |
| `oeN` rises | 13513 |
| Programming supply off | 13530 |
| Raised core supply off | 13780 |
| `doneO` | 13781 |

The monitor samples on the falling clock edge and records the cycle number of every pin transition. When `doneO` appears, it compares the differences between those records with the bench's own rounded interval constants, and it compares `passO` with the entry popped from the scoreboard. The bench's memory model returns valid data only from the thirteenth cycle after output enable falls. A read-back taken too early therefore surfaces as a wrong pass flag.

// File: rtl/eprom_seq_pkg.sv
package eprom_seq_pkg;

  typedef enum logic [2:0] {
    TM_SETUP,
    TM_PULSE,
    TM_HOLD,
    TM_ACCESS,
    TM_FLOAT,
    TM_ONE
  } tmSel_e;

  typedef struct packed {
    logic   latchReq;
    logic   loadTimer;
    tmSel_e timerSel;
    logic   driveBus;
    logic   capture;
  } seqStrb_t;

  function automatic int nsToCycles(input int ns, input int clkKhz);
    longint prod;
    prod = longint'(ns) * longint'(clkKhz);
    return int'((prod + 64'd999999) / 64'd1000000);
  endfunction

endpackage

// File: rtl/eprom_seq_dp.sv
module eprom_seq_dp
  import eprom_seq_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 8,
  parameter int SETUP_CYC = 250,
  parameter int PULSE_CYC = 12500,
  parameter int HOLD_CYC  = 250,
  parameter int ACC_CYC   = 13,
  parameter int FLOAT_CYC = 17,
  parameter int CNT_W     = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrb_t          strb,
  input  logic [ADDR_W-1:0] addrI,
  input  logic [DATA_W-1:0] dataI,
  input  logic [DATA_W-1:0] memDataI,
  output logic [ADDR_W-1:0] memAddrO,
  output logic [DATA_W-1:0] memDataO,
  output logic              busOeO,
  output logic              tmDoneO,
  output logic              passO
);

  logic [CNT_W-1:0]  timerQ;
  logic [CNT_W-1:0]  loadVal;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic              passQ;

  always_comb begin
    unique case (strb.timerSel)
      TM_SETUP:  loadVal = CNT_W'(SETUP_CYC - 1);
      TM_PULSE:  loadVal = CNT_W'(PULSE_CYC - 1);
      TM_HOLD:   loadVal = CNT_W'(HOLD_CYC - 1);
      TM_ACCESS: loadVal = CNT_W'(ACC_CYC - 1);
      TM_FLOAT:  loadVal = CNT_W'(FLOAT_CYC - 1);
      default:   loadVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerQ <= '0;
    end else if (strb.loadTimer) begin
      timerQ <= loadVal;
    end else if (timerQ != '0) begin
      timerQ <= timerQ - 1'b1;
    end
  end

  assign tmDoneO = (timerQ == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      passQ <= 1'b0;
    end else if (strb.latchReq) begin
      addrQ <= addrI;
      dataQ <= dataI;
      passQ <= 1'b0;
    end else if (strb.capture) begin
      passQ <= (memDataI == dataQ);
    end
  end

  assign memAddrO = addrQ;
  assign memDataO = dataQ;
  assign busOeO   = strb.driveBus;
  assign passO    = passQ;

  AST_CAPTURE_BUS_FREE: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |-> !strb.driveBus) else $error("bus driven during read-back"); // R6

  AST_NO_RELATCH_DRIVING: assert property (@(posedge clk) disable iff (!rstN)
    strb.driveBus |=> $stable(addrQ) && $stable(dataQ)) else $error("operands changed mid-operation"); // R11

endmodule

// File: rtl/eprom_seq_ctrl.sv
module eprom_seq_ctrl
  import eprom_seq_pkg::*;
#(
  parameter int PULSE_CYC = 12500,
  parameter int CNT_W     = 14
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     startI,
  input  logic     tmDoneI,
  output seqStrb_t strbO,
  output logic     vccHiEnO,
  output logic     vppEnO,
  output logic     ceN,
  output logic     oeN,
  output logic     pgmN,
  output logic     busyO,
  output logic     doneO
);

  typedef enum logic [3:0] {
    S_IDLE,
    S_VCC_UP,
    S_VPP_UP,
    S_CE_SETUP,
    S_PULSE,
    S_HOLD,
    S_VERIFY,
    S_FLOAT,
    S_VPP_OFF,
    S_VCC_OFF,
    S_DONE
  } state_e;

  state_e stQ, stNxt;

  always_comb begin
    stNxt               = stQ;
    strbO               = '0;
    strbO.timerSel      = TM_ONE;
    strbO.driveBus      = (stQ == S_VPP_UP) || (stQ == S_CE_SETUP) ||
                          (stQ == S_PULSE)  || (stQ == S_HOLD);
    unique case (stQ)
      S_IDLE: if (startI) begin
        stNxt = S_VCC_UP; strbO.latchReq = 1'b1;
        strbO.loadTimer = 1'b1; strbO.timerSel = TM_SETUP;
      end
      S_VCC_UP: if (tmDoneI) begin
        stNxt = S_VPP_UP; strbO.loadTimer = 1'b1; strbO.timerSel = TM_SETUP;
      end
      S_VPP_UP: if (tmDoneI) begin
        stNxt = S_CE_SETUP; strbO.loadTimer = 1'b1; strbO.timerSel = TM_SETUP;
      end
      S_CE_SETUP: if (tmDoneI) begin
        stNxt = S_PULSE; strbO.loadTimer = 1'b1; strbO.timerSel = TM_PULSE;
      end
      S_PULSE: if (tmDoneI) begin
        stNxt = S_HOLD; strbO.loadTimer = 1'b1; strbO.timerSel = TM_HOLD;
      end
      S_HOLD: if (tmDoneI) begin
        stNxt = S_VERIFY; strbO.loadTimer = 1'b1; strbO.timerSel = TM_ACCESS;
      end
      S_VERIFY: if (tmDoneI) begin
        stNxt = S_FLOAT; strbO.capture = 1'b1;
        strbO.loadTimer = 1'b1; strbO.timerSel = TM_FLOAT;
      end
      S_FLOAT: if (tmDoneI) begin
        stNxt = S_VPP_OFF; strbO.loadTimer = 1'b1; strbO.timerSel = TM_SETUP;
      end
      S_VPP_OFF: if (tmDoneI) begin
        stNxt = S_VCC_OFF; strbO.loadTimer = 1'b1; strbO.timerSel = TM_ONE;
      end
      S_VCC_OFF: if (tmDoneI) stNxt = S_DONE;
      S_DONE:    stNxt = S_IDLE;
      default:   stNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stQ <= S_IDLE;
    else       stQ <= stNxt;
  end

  assign vccHiEnO = (stQ != S_IDLE) && (stQ != S_VCC_OFF) && (stQ != S_DONE);
  assign vppEnO   = (stQ == S_VPP_UP) || (stQ == S_CE_SETUP) || (stQ == S_PULSE) ||
                    (stQ == S_HOLD)   || (stQ == S_VERIFY)   || (stQ == S_FLOAT);
  assign ceN      = !((stQ == S_CE_SETUP) || (stQ == S_PULSE) || (stQ == S_HOLD) ||
                      (stQ == S_VERIFY)   || (stQ == S_FLOAT));
  assign pgmN     = (stQ != S_PULSE);
  assign oeN      = (stQ != S_VERIFY);
  assign busyO    = (stQ != S_IDLE);
  assign doneO    = (stQ == S_DONE);

  logic [CNT_W:0] lowCntQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     lowCntQ <= '0;
    else if (pgmN) lowCntQ <= '0;
    else           lowCntQ <= lowCntQ + 1'b1;
  end

  AST_VPP_NEEDS_VCC: assert property (@(posedge clk) disable iff (!rstN)
    vppEnO |-> vccHiEnO) else $error("programming supply without raised core supply"); // R2

  AST_PULSE_CONTEXT: assert property (@(posedge clk) disable iff (!rstN)
    !pgmN |-> (!ceN && oeN && vppEnO && strbO.driveBus)) else $error("bad pins during pulse"); // R5

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pgmN) |-> (lowCntQ == (CNT_W+1)'(PULSE_CYC))) else $error("program pulse width"); // R4

  AST_VERIFY_BUS_FREE: assert property (@(posedge clk) disable iff (!rstN)
    !oeN |-> !strbO.driveBus) else $error("bus driven while output enabled"); // R6

  AST_DONE_SUPPLIES_OFF: assert property (@(posedge clk) disable iff (!rstN)
    doneO |-> (!vppEnO && !vccHiEnO)) else $error("done with supplies on"); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    doneO |=> !doneO) else $error("done longer than one cycle"); // R9

endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
  import eprom_seq_pkg::*;
#(
  parameter int CLK_KHZ     = 125000,
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int T_SETUP_NS  = 2000,
  parameter int T_HOLD_NS   = 2000,
  parameter int T_PULSE_NS  = 100000,
  parameter int T_ACCESS_NS = 100,
  parameter int T_FLOAT_NS  = 130
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startI,
  input  logic [ADDR_W-1:0] addrI,
  input  logic [DATA_W-1:0] dataI,
  output logic              busyO,
  output logic              doneO,
  output logic              passO,
  output logic [ADDR_W-1:0] memAddrO,
  output logic [DATA_W-1:0] memDataO,
  output logic              memDataOeO,
  input  logic [DATA_W-1:0] memDataI,
  output logic              vccHiEnO,
  output logic              vppEnO,
  output logic              ceN,
  output logic              oeN,
  output logic              pgmN
);

  localparam int SETUP_CYC = nsToCycles(T_SETUP_NS, CLK_KHZ);
  localparam int HOLD_CYC  = nsToCycles(T_HOLD_NS, CLK_KHZ);
  localparam int PULSE_CYC = nsToCycles(T_PULSE_NS, CLK_KHZ);
  localparam int ACC_CYC   = nsToCycles(T_ACCESS_NS, CLK_KHZ);
  localparam int FLOAT_CYC = nsToCycles(T_FLOAT_NS, CLK_KHZ);
  localparam int CNT_W     = $clog2(PULSE_CYC + SETUP_CYC + HOLD_CYC + 2);

  seqStrb_t strb;
  logic     tmDone;

  eprom_seq_ctrl #(
    .PULSE_CYC(PULSE_CYC),
    .CNT_W    (CNT_W)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .startI  (startI),
    .tmDoneI (tmDone),
    .strbO   (strb),
    .vccHiEnO(vccHiEnO),
    .vppEnO  (vppEnO),
    .ceN     (ceN),
    .oeN     (oeN),
    .pgmN    (pgmN),
    .busyO   (busyO),
    .doneO   (doneO)
  );

  eprom_seq_dp #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .SETUP_CYC(SETUP_CYC),
    .PULSE_CYC(PULSE_CYC),
    .HOLD_CYC (HOLD_CYC),
    .ACC_CYC  (ACC_CYC),
    .FLOAT_CYC(FLOAT_CYC),
    .CNT_W    (CNT_W)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .addrI   (addrI),
    .dataI   (dataI),
    .memDataI(memDataI),
    .memAddrO(memAddrO),
    .memDataO(memDataO),
    .busOeO  (memDataOeO),
    .tmDoneO (tmDone),
    .passO   (passO)
  );

endmodule

// File: tb/eprom_prog_seq_test.sv
`timescale 1ns/1ps
module eprom_prog_seq_test;

  localparam int PERIOD_NS = 8;
  localparam int SETUP  = (2000   + PERIOD_NS - 1) / PERIOD_NS;
  localparam int PULSE  = (100000 + PERIOD_NS - 1) / PERIOD_NS;
  localparam int ACCESS = (100    + PERIOD_NS - 1) / PERIOD_NS;
  localparam int FLOAT  = (130    + PERIOD_NS - 1) / PERIOD_NS;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startI = 1'b0;
  logic [12:0] addrI = '0;
  logic [7:0]  dataI = '0;
  logic        busyO, doneO, passO, memDataOeO;
  logic [12:0] memAddrO;
  logic [7:0]  memDataO, memDataI;
  logic        vccHiEnO, vppEnO, ceN, oeN, pgmN;

  always #(PERIOD_NS/2) clk = ~clk;

  eprom_prog_seq uut (
    .clk(clk), .rstN(rstN), .startI(startI), .addrI(addrI), .dataI(dataI),
    .busyO(busyO), .doneO(doneO), .passO(passO), .memAddrO(memAddrO),
    .memDataO(memDataO), .memDataOeO(memDataOeO), .memDataI(memDataI),
    .vccHiEnO(vccHiEnO), .vppEnO(vppEnO), .ceN(ceN), .oeN(oeN), .pgmN(pgmN)
  );

  int testCnt = 0;
  int failCnt = 0;
  int doneCnt = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // memory model: bits only clear; data valid from the ACCESS-th cycle of output enable
  bit [7:0] cells  [8192];
  bit [7:0] shadow [8192];
  int       oeLowCnt = 0;

  initial for (int i = 0; i < 8192; i++) begin cells[i] = 8'hFF; shadow[i] = 8'hFF; end

  always @(posedge clk) begin
    oeLowCnt <= (!oeN && !ceN) ? oeLowCnt + 1 : 0;
    if (rstN && !pgmN && !ceN && oeN && vppEnO && vccHiEnO && memDataOeO)
      cells[memAddrO] <= cells[memAddrO] & memDataO;
  end

  assign memDataI = (!oeN && !ceN && oeLowCnt >= ACCESS - 1) ? cells[memAddrO] : 8'h5A;

  typedef struct { logic [12:0] a; logic [7:0] d; bit p; } item_t;
  item_t q[$];
  bit    lastPass = 1'b0;

  // monitor
  longint cyc = 0;
  longint tVccR, tVccF, tVppR, tVppF, tCeF, tCeR, tPgmF, tPgmR, tOeF, tOeR, tBusR, tBusF;
  logic pVcc = 0, pVpp = 0, pCe = 1, pPgm = 1, pOe = 1, pBus = 0;

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (vccHiEnO && !pVcc) tVccR = cyc;
      if (!vccHiEnO && pVcc) tVccF = cyc;
      if (vppEnO && !pVpp)   tVppR = cyc;
      if (!vppEnO && pVpp)   tVppF = cyc;
      if (!ceN && pCe)       tCeF = cyc;
      if (ceN && !pCe)       tCeR = cyc;
      if (!oeN && pOe)       tOeF = cyc;
      if (oeN && !pOe)       tOeR = cyc;
      if (memDataOeO && !pBus) tBusR = cyc;
      if (!memDataOeO && pBus) tBusF = cyc;
      if (pgmN && !pPgm)     tPgmR = cyc;
      if (!pgmN && pPgm) begin
        tPgmF = cyc;
        if (q.size() > 0) begin
          chk(memAddrO == q[0].a, "R11", "address at pulse", memAddrO, q[0].a);
          chk(memDataO == q[0].d, "R11", "data at pulse", memDataO, q[0].d);
        end
      end
      if (doneO) begin
        doneCnt++;
        if (q.size() == 0) begin
          chk(1'b0, "R10", "unexpected done", 1, 0);
        end else begin
          item_t it;
          it = q.pop_front();
          chk(passO == it.p, "R7", "pass flag", passO, it.p);
          chk(tVppR - tVccR == SETUP, "R2", "vcc->vpp on", tVppR - tVccR, SETUP);
          chk(tVccF - tVppF == SETUP, "R2", "vpp->vcc off", tVccF - tVppF, SETUP);
          chk(tPgmF - tBusR == 2*SETUP, "R3", "bus drive->pulse", tPgmF - tBusR, 2*SETUP);
          chk(tPgmF - tCeF == SETUP, "R3", "ce->pulse", tPgmF - tCeF, SETUP);
          chk(tPgmR - tPgmF == PULSE, "R4", "pulse width", tPgmR - tPgmF, PULSE);
          chk(tBusF - tPgmR == SETUP, "R6", "data hold", tBusF - tPgmR, SETUP);
          chk(tOeF == tBusF, "R6", "oe fall vs bus release", tOeF, tBusF);
          chk(tOeR - tOeF == ACCESS, "R7", "oe low width", tOeR - tOeF, ACCESS);
          chk(tVppF - tOeR == FLOAT, "R8", "oe rise->vpp off", tVppF - tOeR, FLOAT);
          chk(tCeR - tOeR == FLOAT, "R8", "oe rise->ce off", tCeR - tOeR, FLOAT);
          chk(cyc - tVccF == 1, "R9", "vcc off->done", cyc - tVccF, 1);
          chk(!vppEnO && !vccHiEnO, "R9", "supplies at done", {vppEnO, vccHiEnO}, 0);
        end
      end
    end
    pVcc = vccHiEnO; pVpp = vppEnO; pCe = ceN; pPgm = pgmN; pOe = oeN; pBus = memDataOeO;
  end

  // driver
  task automatic doWrite(input logic [12:0] a, input logic [7:0] d, input bit disturb);
    item_t it;
    while (busyO) @(negedge clk);
    it.a = a; it.d = d; it.p = ((shadow[a] & d) == d);
    shadow[a] = shadow[a] & d;
    q.push_back(it);
    startI = 1'b1; addrI = a; dataI = d;
    @(negedge clk);
    startI = 1'b0; addrI = ~a; dataI = ~d;
    chk(busyO == 1'b1, "R10", "busy after start", busyO, 1);
    if (disturb) begin
      repeat (1000) @(negedge clk);
      startI = 1'b1; addrI = 13'h0456; dataI = 8'h11;
      @(negedge clk);
      startI = 1'b0;
    end
    while (busyO) @(negedge clk);
    lastPass = it.p;
    repeat (3) @(negedge clk);
    chk(passO == lastPass, "R9", "pass held after done", passO, lastPass);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(!vccHiEnO && !vppEnO && ceN && oeN && pgmN && !memDataOeO &&
        !busyO && !doneO && !passO, "R1", "outputs in reset", 0, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(!vccHiEnO && !vppEnO && ceN && oeN && pgmN && !memDataOeO &&
        !busyO && !doneO && !passO, "R1", "outputs after reset", 0, 0);

    doWrite(13'h0123, 8'h3C, 1'b1);  // R10 R11: ignored start and input changes
    doWrite(13'h1FFF, 8'h00, 1'b0);  // top address, all bits cleared
    doWrite(13'h0123, 8'hC3, 1'b0);  // R7: bits already cleared -> verify fails
    doWrite(13'h0000, 8'hFF, 1'b0);  // blank byte

    repeat (5) @(negedge clk);
    chk(doneCnt == 4, "R10", "done count", doneCnt, 4);
    chk(q.size() == 0, "R10", "scoreboard drained", q.size(), 0);
    chk(cells[13'h0456] == 8'hFF, "R10", "ignored address untouched", cells[13'h0456], 8'hFF);

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    testCnt++;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule